// File: doc/BRIEF.md
# Keyed-Sequence Watchdog Timer

This block is a memory-mapped watchdog built around an up-counter that runs from a slow tick strobe. The tick is nominally 32 kHz and is presented as a one-cycle enable in the bus clock domain. An optional prescaler divides the tick by a power of two. When the counter wraps past its all-ones value it reloads from the load register. If the watchdog is armed at that moment, it also emits a one-cycle reset pulse.

Software arms the watchdog by writing an ordered pair of 16-bit keys to the key register. A different ordered pair disarms it, and the block then keeps counting as a plain timer. Software keeps the watchdog from firing by writing the trigger register with a value that differs from the previous trigger value. That write reloads the counter.

Writes to the control, load, trigger and key registers are posted. Each of these four registers has its own pending flag. A posted write takes effect only when its flag clears, which happens a fixed number of ticks after the write.

Top module: `wdt_keyed`

## Requirements
- R1: After reset the counter equals LOAD_INIT, the pending register reads 0, the run bit reads 0, the system config register reads 0, no reset pulse is issued, and bits 7:0 of word 0 read the REV parameter.
- R2: A write to a posted register sets its flag in the pending register (word 7). The flags are: control at bit 0, load at bit 2, trigger at bit 3 and key at bit 4. The flag stays set for PEND_TICKS ticks and then clears. The written value takes effect only when the flag clears.
- R3: The control register is word 2. Bit 5 enables the prescaler and bits 4:2 hold the ratio n. With the prescaler enabled the counter advances once every 2^n ticks; with it disabled the counter advances on every tick.
- R4: The counter (word 3) counts upward on each advance and holds its value between advances.
- R5: A trigger write (word 5) whose value differs from the last trigger value reloads the counter from the load register (word 4) and restarts the prescaler. The last trigger value is 0 after reset.
- R6: A trigger write that repeats the last trigger value leaves the counter untouched.
- R7: Writing 0xBBBB and then 0x4444 to bits 15:0 of the key register (word 6) arms the watchdog. Bit 0 of word 6 reads back the run state.
- R8: Writing 0xAAAA and then 0x5555 to the key register disarms the watchdog.
- R9: A key write that breaks an expected pair returns the sequence checker to idle and leaves the run state unchanged.
- R10: While the watchdog is armed, a wrap past the all-ones value reloads the counter from the load register and drives the reset output high for exactly one cycle.
- R11: While the watchdog is disarmed, a wrap reloads the counter from the load register and issues no reset pulse.
- R12: Bit 0 of the system config register (word 1), the interface-clock autogate enable, is written directly and reads back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle strobe at the slow counting rate |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register word index |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| wdt_rst_o | output | 1 | One-cycle watchdog reset pulse |

## Verification
The bench walks the prescaler ratios at the exact tick counts where one ratio too many or too few would change the count. It also reads a posted register while its write is still pending, so a design that applied the write early is caught. Key sequences broken by a foreign key or by the opposite key's first half are tried. A checker that only looked at the last key would arm or disarm on them. A repeated trigger value is tested because a reload on every trigger write would hide the counter's advance. Wraps with the watchdog armed and disarmed expose a missing reload, a stuck or absent reset pulse, or a pulse fired while disarmed.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
   localparam int unsigned BUS_W = 32;
   localparam int unsigned AW    = 3;
   localparam int unsigned NSLOT = 4;

   typedef enum logic [AW-1:0] {
      A_REV  = 3'd0,
      A_SYSC = 3'd1,
      A_CTRL = 3'd2,
      A_CNT  = 3'd3,
      A_LOAD = 3'd4,
      A_TRIG = 3'd5,
      A_KEY  = 3'd6,
      A_PEND = 3'd7
   } reg_addr_e;

   // posted slots: 0 control, 1 load, 2 trigger, 3 key
   localparam logic [AW-1:0] SLOT_ADDR [NSLOT] = '{3'd2, 3'd4, 3'd5, 3'd6};
   localparam int unsigned   SLOT_PBIT [NSLOT] = '{0, 2, 3, 4};

   localparam logic [15:0] KEY_ARM_1  = 16'hBBBB;
   localparam logic [15:0] KEY_ARM_2  = 16'h4444;
   localparam logic [15:0] KEY_SAFE_1 = 16'hAAAA;
   localparam logic [15:0] KEY_SAFE_2 = 16'h5555;

   typedef enum logic [1:0] {KS_IDLE, KS_ARM, KS_SAFE} key_st_e;
endpackage

// File: rtl/wdt_post_slot.sv
module wdt_post_slot #(
   parameter int unsigned DW         = 32,
   parameter int unsigned PEND_TICKS = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic          wr,
   input  logic [DW-1:0] wdata,
   output logic          busy,
   output logic          commit,
   output logic [DW-1:0] data
);
   localparam int unsigned CW = $clog2(PEND_TICKS + 1);

   logic [CW-1:0] left_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         commit <= 1'b0;
         left_q <= '0;
         data   <= '0;
      end else begin
         commit <= 1'b0;
         if (wr) begin
            data   <= wdata;
            busy   <= 1'b1;
            left_q <= CW'(PEND_TICKS);
         end else if (tick && busy) begin
            if (left_q == CW'(1)) begin
               busy   <= 1'b0;
               commit <= 1'b1;
               left_q <= '0;
            end else begin
               left_q <= left_q - CW'(1);
            end
         end
      end
   end
endmodule

// File: rtl/wdt_key_seq.sv
module wdt_key_seq
   import wdt_pkg::*;
#(
   parameter bit START_ON = 1'b0
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        commit,
   input  logic [15:0] key,
   output logic        run
);
   key_st_e st_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q <= KS_IDLE;
         run  <= START_ON;
      end else if (commit) begin
         unique case (st_q)
            KS_IDLE: begin
               if (key == KEY_ARM_1)       st_q <= KS_ARM;
               else if (key == KEY_SAFE_1) st_q <= KS_SAFE;
               else                        st_q <= KS_IDLE;
            end
            KS_ARM: begin
               if (key == KEY_ARM_2) run <= 1'b1;
               st_q <= KS_IDLE;
            end
            KS_SAFE: begin
               if (key == KEY_SAFE_2) run <= 1'b0;
               st_q <= KS_IDLE;
            end
            default: st_q <= KS_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/wdt_count.sv
module wdt_count #(
   parameter int unsigned CNT_W        = 32,
   parameter int unsigned PTV_W        = 3,
   parameter bit          HAS_PRESCALE = 1'b1,
   parameter logic [CNT_W-1:0] LOAD_INIT = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             pre_en,
   input  logic [PTV_W-1:0] ptv,
   input  logic             pre_clr,
   input  logic             reload,
   input  logic [CNT_W-1:0] load_val,
   input  logic             run,
   output logic [CNT_W-1:0] cnt,
   output logic             wdt_rst
);
   localparam int unsigned PRE_W = (1 << PTV_W) - 1;

   logic advance;

   generate
      if (HAS_PRESCALE) begin : g_pre
         logic [PRE_W-1:0] pre_q;
         logic [PRE_W-1:0] limit;
         assign limit   = (PRE_W'(1) << ptv) - PRE_W'(1);
         assign advance = tick && (!pre_en || pre_q == limit);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                        pre_q <= '0;
            else if (pre_clr || reload || !pre_en) pre_q <= '0;
            else if (tick)                     pre_q <= (pre_q == limit) ? '0 : pre_q + PRE_W'(1);
         end
      end else begin : g_nopre
         assign advance = tick;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt     <= LOAD_INIT;
         wdt_rst <= 1'b0;
      end else begin
         wdt_rst <= 1'b0;
         if (reload) begin
            cnt <= load_val;
         end else if (advance) begin
            if (&cnt) begin
               cnt     <= load_val;
               wdt_rst <= run;
            end else begin
               cnt <= cnt + CNT_W'(1);
            end
         end
      end
   end
endmodule

// File: rtl/wdt_keyed.sv
module wdt_keyed
   import wdt_pkg::*;
#(
   parameter int unsigned      CNT_W        = 32,
   parameter int unsigned      PEND_TICKS   = 2,
   parameter logic [7:0]       REV          = 8'h21,
   parameter bit               START_ON     = 1'b0,
   parameter bit               HAS_PRESCALE = 1'b1,
   parameter logic [CNT_W-1:0] LOAD_INIT    = '0
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        tick_i,
   input  logic        wr_en_i,
   input  logic [2:0]  addr_i,
   input  logic [31:0] wdata_i,
   output logic [31:0] rdata_o,
   output logic        wdt_rst_o
);
   localparam int unsigned PTV_W = 3;

   generate
      if (CNT_W < 8 || CNT_W > BUS_W) begin : g_bad_w
         $error("CNT_W must lie in 8..32");
      end
      if (PEND_TICKS < 1) begin : g_bad_p
         $error("PEND_TICKS must be at least 1");
      end
   endgenerate

   logic [NSLOT-1:0] busy_w, commit_w;
   logic [BUS_W-1:0] sdata_w [NSLOT];
   logic [4:0]       pend_w;

   generate
      for (genvar g = 0; g < NSLOT; g++) begin : g_slot
         wdt_post_slot #(.DW(BUS_W), .PEND_TICKS(PEND_TICKS)) slot_i (
            .clk   (clk),
            .rst_n (rst_n),
            .tick  (tick_i),
            .wr    (wr_en_i && addr_i == SLOT_ADDR[g]),
            .wdata (wdata_i),
            .busy  (busy_w[g]),
            .commit(commit_w[g]),
            .data  (sdata_w[g])
         );
      end
   endgenerate

   always_comb begin
      pend_w = '0;
      for (int i = 0; i < NSLOT; i++) pend_w[SLOT_PBIT[i]] = busy_w[i];
   end

   logic [5:0]       ctrl_q;
   logic [CNT_W-1:0] load_q;
   logic [BUS_W-1:0] last_trig_q;
   logic             sysc_q;
   logic             run_w;
   logic             trig_hit;
   logic [CNT_W-1:0] cnt_w;

   assign trig_hit = commit_w[2] && (sdata_w[2] != last_trig_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q      <= '0;
         load_q      <= LOAD_INIT;
         last_trig_q <= '0;
         sysc_q      <= 1'b0;
      end else begin
         if (commit_w[0]) ctrl_q <= sdata_w[0][5:0];
         if (commit_w[1]) load_q <= sdata_w[1][CNT_W-1:0];
         if (commit_w[2]) last_trig_q <= sdata_w[2];
         if (wr_en_i && addr_i == A_SYSC) sysc_q <= wdata_i[0];
      end
   end

   wdt_key_seq #(.START_ON(START_ON)) key_i (
      .clk   (clk),
      .rst_n (rst_n),
      .commit(commit_w[3]),
      .key   (sdata_w[3][15:0]),
      .run   (run_w)
   );

   wdt_count #(
      .CNT_W(CNT_W), .PTV_W(PTV_W), .HAS_PRESCALE(HAS_PRESCALE), .LOAD_INIT(LOAD_INIT)
   ) cnt_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick_i),
      .pre_en  (ctrl_q[5]),
      .ptv     (ctrl_q[4:2]),
      .pre_clr (commit_w[0]),
      .reload  (trig_hit),
      .load_val(load_q),
      .run     (run_w),
      .cnt     (cnt_w),
      .wdt_rst (wdt_rst_o)
   );

   always_comb begin
      rdata_o = '0;
      unique case (addr_i)
         A_REV:  rdata_o = {24'd0, REV};
         A_SYSC: rdata_o = {31'd0, sysc_q};
         A_CTRL: rdata_o = {26'd0, ctrl_q};
         A_CNT:  rdata_o = BUS_W'(cnt_w);
         A_LOAD: rdata_o = BUS_W'(load_q);
         A_TRIG: rdata_o = last_trig_q;
         A_KEY:  rdata_o = {31'd0, run_w};
         A_PEND: rdata_o = {27'd0, pend_w};
         default: rdata_o = '0;
      endcase
   end
endmodule

// File: rtl/wdt_keyed_chk.sv
module wdt_keyed_chk #(
   parameter int unsigned CNT_W = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             tick,
   input logic             wr_en,
   input logic [2:0]       addr,
   input logic [4:0]       pend,
   input logic             run,
   input logic [CNT_W-1:0] cnt,
   input logic             rst_o,
   input logic             key_commit,
   input logic             trig_hit
);
   p_pulse_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
      rst_o |=> !rst_o);

   p_pulse_armed_r11: assert property (@(posedge clk) disable iff (!rst_n)
      rst_o |-> $past(run));

   p_load_flag_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend[2]) |-> $past(wr_en && addr == 3'd4));

   p_flags_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !wr_en) |=> $stable(pend));

   p_run_on_key_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !key_commit |=> $stable(run));

   p_cnt_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !trig_hit) |=> $stable(cnt));
endmodule

bind wdt_keyed wdt_keyed_chk #(.CNT_W(CNT_W)) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .tick      (tick_i),
   .wr_en     (wr_en_i),
   .addr      (addr_i),
   .pend      (pend_w),
   .run       (run_w),
   .cnt       (cnt_w),
   .rst_o     (wdt_rst_o),
   .key_commit(commit_w[3]),
   .trig_hit  (trig_hit)
);

// File: tb/wdt_keyed_tb_top.sv
module wdt_keyed_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_i = 1'b0;
   logic        wr_en_i = 1'b0;
   logic [2:0]  addr_i = 3'd0;
   logic [31:0] wdata_i = 32'd0;
   logic [31:0] rdata_o;
   logic        wdt_rst_o;

   int errors = 0;
   int checks = 0;
   int pulses = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   wdt_keyed dut_i (
      .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wr_en_i(wr_en_i),
      .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .wdt_rst_o(wdt_rst_o)
   );

   always @(posedge clk) if (wdt_rst_o) pulses++;

   // {prescaler enable, ratio, ticks, expected advances}
   localparam int NV = 6;
   localparam logic [31:0] VEC [NV][4] = '{
      '{32'd0, 32'd0, 32'd5,  32'd5},
      '{32'd0, 32'd1, 32'd5,  32'd5},
      '{32'd1, 32'd0, 32'd5,  32'd5},
      '{32'd1, 32'd1, 32'd5,  32'd2},
      '{32'd1, 32'd2, 32'd9,  32'd2},
      '{32'd1, 32'd3, 32'd17, 32'd2}
   };

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(logic [2:0] a, logic [31:0] d);
      @(negedge clk);
      wr_en_i = 1'b1; addr_i = a; wdata_i = d;
      @(negedge clk);
      wr_en_i = 1'b0;
   endtask

   task automatic rd(logic [2:0] a, output logic [31:0] d);
      @(negedge clk);
      addr_i = a;
      #1 d = rdata_o;
   endtask

   task automatic ticks(int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); tick_i = 1'b1;
         @(negedge clk); tick_i = 1'b0;
         @(negedge clk);
      end
   endtask

   task automatic posted(logic [2:0] a, logic [31:0] d);
      wr(a, d);
      ticks(2);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [31:0] v, c;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd(3'd0, v); check("R1 rev", {24'd0, v[7:0]}, 32'h21);
      rd(3'd7, v); check("R1 pend", v, 0);
      rd(3'd3, v); check("R1 cnt", v, 0);
      rd(3'd6, v); check("R1 run", v, 0);
      rd(3'd1, v); check("R1 sysc", v, 0);
      check("R1 pulses", pulses, 0);

      // R12 autogate bit
      wr(3'd1, 32'h1); rd(3'd1, v); check("R12 sysc", v, 1);

      // R2 pending flags and posted effect
      wr(3'd2, 32'h0); wr(3'd4, 32'h100); wr(3'd5, 32'h11); wr(3'd6, 32'h0);
      rd(3'd7, v); check("R2 pend set", v, 32'h1D);
      rd(3'd4, v); check("R2 load not yet applied", v, 0);
      ticks(1);
      rd(3'd7, v); check("R2 pend after 1 tick", v, 32'h1D);
      ticks(1);
      rd(3'd7, v); check("R2 pend clear", v, 0);
      rd(3'd4, v); check("R2 load applied", v, 32'h100);

      // R4 counting (trigger reload used the old load 0)
      posted(3'd5, 32'h12);
      rd(3'd3, v); check("R5 reload", v, 32'h100);
      ticks(3);
      rd(3'd3, v); check("R4 count up", v, 32'h103);

      // R3 prescaler table
      for (int i = 0; i < NV; i++) begin
         posted(3'd2, (VEC[i][0] << 5) | (VEC[i][1] << 2));
         posted(3'd5, 32'h40 + i);
         rd(3'd3, v); check("R5 reload vec", v, 32'h100);
         ticks(VEC[i][2]);
         rd(3'd3, v); check("R3 prescale vec", v, 32'h100 + VEC[i][3]);
      end

      // R6 repeated trigger ignored
      posted(3'd2, 32'h0);
      rd(3'd3, c);
      posted(3'd5, 32'h45);
      rd(3'd3, v); check("R6 same trigger", v, c + 2);
      posted(3'd5, 32'h77);
      rd(3'd3, v); check("R5 new trigger", v, 32'h100);

      // R9 broken arm sequence, R7 arm
      posted(3'd6, 32'hBBBB); posted(3'd6, 32'hAAAA); posted(3'd6, 32'h4444);
      rd(3'd6, v); check("R9 broken arm", v, 0);
      posted(3'd6, 32'hBBBB); posted(3'd6, 32'h4444);
      rd(3'd6, v); check("R7 armed", v, 1);

      // R10 armed wrap
      posted(3'd4, 32'hFFFF_FFF0);
      posted(3'd5, 32'h99);
      rd(3'd3, v); check("R5 reload high", v, 32'hFFFF_FFF0);
      ticks(15);
      rd(3'd3, v); check("R10 at top", v, 32'hFFFF_FFFF);
      check("R10 no early pulse", pulses, 0);
      ticks(1);
      check("R10 one pulse", pulses, 1);
      rd(3'd3, v); check("R10 reload", v, 32'hFFFF_FFF0);

      // R9 broken disarm, R8 disarm
      posted(3'd6, 32'hAAAA); posted(3'd6, 32'h1234); posted(3'd6, 32'h5555);
      rd(3'd6, v); check("R9 broken disarm", v, 1);
      posted(3'd6, 32'hAAAA); posted(3'd6, 32'h5555);
      rd(3'd6, v); check("R8 disarmed", v, 0);

      // R11 disarmed wrap
      rd(3'd3, c);
      ticks(int'(32'hFFFF_FFFF - c) + 1);
      check("R11 no pulse", pulses, 1);
      rd(3'd3, v); check("R11 reload", v, 32'hFFFF_FFF0);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule